// File: doc/BRIEF.md
# Multiply-Extended By-Element Instruction Decoder

This block decodes the 32-bit instruction words of the by-element multiply-extended family. That family has four encoding classes: scalar half precision, scalar single/double precision, vector half precision and vector single/double precision. From each word it works out several things:

- whether the word belongs to the family, and whether it is undefined;
- whether the operation is scalar or vector;
- the three register numbers;
- the element size, the operand data size and the element count;
- the element index into the second source, and the width of the register read that supplies that element.

The index and the second register number are assembled from the scattered H, L and M bits, and the way they combine depends on precision.

The decoder sits in an instruction pipeline stage. Each cycle it takes one word and a half-precision enable bit. Its outputs are registered, so they show the decode of the word sampled at the previous rising clock edge.

Top module: `mxe_decoder`

## Requirements
- R1: A word belongs to the family only when all of the following fixed bits hold: bit31=0, bit29=1, bits27:24=1111, bits15:12=1001 and bit10=0. In addition, either bit28=0 (vector class, bit30 is Q) or bit28=1 with bit30=1 (scalar class), and bits23:22 must be 00 (half) or 1x (single/double, sz=bit22). Any other word gives match_o=0, undef_o=0 and all other outputs 0.
- R2: Outputs are registered with one cycle of latency. A synchronous active-high reset clears every output to 0.
- R3: rd_o equals bits4:0 and rn_o equals bits9:5 of a defined word.
- R4: For half classes rm_o is bits19:16 zero-extended, so only registers 0 to 15 are reachable. For single/double classes rm_o is bits20:16.
- R5: For half classes index_o = {H,L,M}, where H=bit11, L=bit21 and M=bit20.
- R6: For single/double classes, index_o = {H,L} when sz=0 and index_o = H when sz=1 and L=0. The combination sz=1 with L=1 is undefined.
- R7: esize_o is 16 for half classes. For single/double classes it is 32 when sz=0 and 64 when sz=1.
- R8: idx_width_o is 64 when H=0 and 128 when H=1.
- R9: For vector classes dsize_o is 64 when Q=0 and 128 when Q=1, and count_o is dsize_o divided by esize_o. For scalar classes dsize_o equals esize_o and count_o is 1.
- R10: A vector single/double word with sz=1 and Q=0 is undefined.
- R11: A half-precision class word is undefined when half_en_i is 0.
- R12: An undefined word gives match_o=1 and undef_o=1, with every other output 0.
- R13: vector_o is 1 for the two vector classes and 0 for the scalar classes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word |
| half_en_i | input | 1 | Half-precision support enable |
| match_o | output | 1 | Word belongs to the family |
| undef_o | output | 1 | Word is an undefined encoding |
| vector_o | output | 1 | Vector (1) or scalar (0) form |
| rd_o | output | 5 | Destination register |
| rn_o | output | 5 | First source register |
| rm_o | output | 5 | Second source register |
| index_o | output | 3 | Element index into the second source |
| esize_o | output | SIZE_W | Element size in bits |
| dsize_o | output | SIZE_W | Operand data size in bits |
| count_o | output | CNT_W | Number of elements |
| idx_width_o | output | SIZE_W | Width of the indexed register read in bits |

## Verification
The assertions take two things for granted. First, insn_i and half_en_i settle before each rising edge. Second, the checker taps the H, L, M and precision bits straight from the word that was sampled one edge earlier. The stimulus changes inputs only at falling edges and holds each word for a full cycle. It sweeps every class pattern, every precision code and every combination of H, L, M, Q and the half-enable, which includes the non-matching precision code 01 and scalar words with bit30 clear. It then adds single-bit corruptions of the fixed bits and pseudo-random words, which mostly exercise the no-match path.

// File: rtl/mxe_pkg.sv
package mxe_pkg;

  typedef enum logic [2:0] {
    MXE_NONE   = 3'd0,
    MXE_SCL_H  = 3'd1,
    MXE_SCL_SD = 3'd2,
    MXE_VEC_H  = 3'd3,
    MXE_VEC_SD = 3'd4
  } mxe_class_e;

  typedef struct packed {
    logic       q;
    logic       sz;
    logic       l;
    logic       m;
    logic       h;
    logic [3:0] rm_lo;
    logic [4:0] rn;
    logic [4:0] rd;
  } mxe_fields_t;

  function automatic logic cls_is_half(mxe_class_e c);
    return (c == MXE_SCL_H) || (c == MXE_VEC_H);
  endfunction

  function automatic logic cls_is_vec(mxe_class_e c);
    return (c == MXE_VEC_H) || (c == MXE_VEC_SD);
  endfunction

endpackage

// File: rtl/mxe_class_match.sv
module mxe_class_match
  import mxe_pkg::*;
#(
  parameter int INSN_W = 32
) (
  input  logic [INSN_W-1:0] insn,
  output mxe_class_e        cls,
  output mxe_fields_t       fld
);

  logic fixed_ok;
  logic prec_half;
  logic prec_sd;
  logic form_scalar;
  logic form_vector;

  always_comb begin
    fixed_ok    = !insn[31] && insn[29] && (insn[27:24] == 4'hF) &&
                  (insn[15:12] == 4'h9) && !insn[10];
    prec_half   = (insn[23:22] == 2'b00);
    prec_sd     = insn[23];
    form_scalar = insn[28] && insn[30];
    form_vector = !insn[28];

    cls = MXE_NONE;
    if (fixed_ok) begin
      if (form_scalar && prec_half)      cls = MXE_SCL_H;
      else if (form_scalar && prec_sd)   cls = MXE_SCL_SD;
      else if (form_vector && prec_half) cls = MXE_VEC_H;
      else if (form_vector && prec_sd)   cls = MXE_VEC_SD;
    end

    fld.q     = insn[30];
    fld.sz    = insn[22];
    fld.l     = insn[21];
    fld.m     = insn[20];
    fld.h     = insn[11];
    fld.rm_lo = insn[19:16];
    fld.rn    = insn[9:5];
    fld.rd    = insn[4:0];
  end

endmodule

// File: rtl/mxe_operand_map.sv
module mxe_operand_map
  import mxe_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int IDX_W = 3
) (
  input  mxe_class_e       cls,
  input  logic             sz,
  input  logic             l,
  input  logic             m,
  input  logic             h,
  input  logic [REG_W-2:0] rm_lo,
  output logic [REG_W-1:0] rm,
  output logic [IDX_W-1:0] idx,
  output logic             idx_rsv
);

  logic half;

  always_comb begin
    half    = cls_is_half(cls);
    rm      = '0;
    idx     = '0;
    idx_rsv = 1'b0;
    if (half) begin
      rm  = {1'b0, rm_lo};
      idx = IDX_W'({h, l, m});
    end else begin
      rm = {m, rm_lo};
      case ({sz, l})
        2'b00, 2'b01: idx = IDX_W'({h, l});
        2'b10:        idx = IDX_W'(h);
        default: begin
          idx     = '0;
          idx_rsv = (cls != MXE_NONE);
        end
      endcase
    end
  end

endmodule

// File: rtl/mxe_size_calc.sv
module mxe_size_calc
  import mxe_pkg::*;
#(
  parameter int SIZE_W = 8,
  parameter int CNT_W  = 4
) (
  input  mxe_class_e        cls,
  input  logic              sz,
  input  logic              q,
  input  logic              h,
  output logic [SIZE_W-1:0] esize,
  output logic [SIZE_W-1:0] dsize,
  output logic [CNT_W-1:0]  count,
  output logic [SIZE_W-1:0] idx_width,
  output logic              arr_rsv
);

  localparam logic [2:0] LOG_HALF = 3'd4;
  localparam logic [2:0] LOG_WORD = 3'd5;
  localparam logic [2:0] LOG_D64  = 3'd6;
  localparam logic [SIZE_W-1:0] ONE_S = SIZE_W'(1);
  localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);

  logic [2:0] log_e;
  logic [2:0] log_d;
  logic       half;
  logic       vec;

  always_comb begin
    half      = cls_is_half(cls);
    vec       = cls_is_vec(cls);
    log_e     = half ? LOG_HALF : (LOG_WORD + 3'(sz));
    log_d     = vec ? (LOG_D64 + 3'(q)) : log_e;
    arr_rsv   = (cls == MXE_VEC_SD) && sz && !q;
    esize     = ONE_S << log_e;
    dsize     = ONE_S << log_d;
    count     = (log_d >= log_e) ? (ONE_C << (log_d - log_e)) : ONE_C;
    idx_width = ONE_S << (LOG_D64 + 3'(h));
  end

endmodule

// File: rtl/mxe_decoder.sv
module mxe_decoder
  import mxe_pkg::*;
#(
  parameter int SIZE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       insn_i,
  input  logic              half_en_i,
  output logic              match_o,
  output logic              undef_o,
  output logic              vector_o,
  output logic [4:0]        rd_o,
  output logic [4:0]        rn_o,
  output logic [4:0]        rm_o,
  output logic [2:0]        index_o,
  output logic [SIZE_W-1:0] esize_o,
  output logic [SIZE_W-1:0] dsize_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [SIZE_W-1:0] idx_width_o
);

  localparam int INSN_W = 32;
  localparam int REG_W  = 5;
  localparam int IDX_W  = 3;

  mxe_class_e  cls;
  mxe_fields_t fld;
  logic [REG_W-1:0]  rm_c;
  logic [IDX_W-1:0]  idx_c;
  logic              idx_rsv;
  logic [SIZE_W-1:0] es_c;
  logic [SIZE_W-1:0] ds_c;
  logic [CNT_W-1:0]  cnt_c;
  logic [SIZE_W-1:0] iw_c;
  logic              arr_rsv;

  mxe_class_match #(.INSN_W(INSN_W)) u_match (
    .insn (insn_i),
    .cls  (cls),
    .fld  (fld)
  );

  mxe_operand_map #(.REG_W(REG_W), .IDX_W(IDX_W)) u_opmap (
    .cls     (cls),
    .sz      (fld.sz),
    .l       (fld.l),
    .m       (fld.m),
    .h       (fld.h),
    .rm_lo   (fld.rm_lo),
    .rm      (rm_c),
    .idx     (idx_c),
    .idx_rsv (idx_rsv)
  );

  mxe_size_calc #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_size (
    .cls       (cls),
    .sz        (fld.sz),
    .q         (fld.q),
    .h         (fld.h),
    .esize     (es_c),
    .dsize     (ds_c),
    .count     (cnt_c),
    .idx_width (iw_c),
    .arr_rsv   (arr_rsv)
  );

  logic              hit;
  logic              bad;
  logic              live;
  logic              n_vec;
  logic [REG_W-1:0]  n_rd;
  logic [REG_W-1:0]  n_rn;
  logic [REG_W-1:0]  n_rm;
  logic [IDX_W-1:0]  n_idx;
  logic [SIZE_W-1:0] n_es;
  logic [SIZE_W-1:0] n_ds;
  logic [CNT_W-1:0]  n_cnt;
  logic [SIZE_W-1:0] n_iw;

  always_comb begin
    hit   = (cls != MXE_NONE);
    bad   = hit && ((cls_is_half(cls) && !half_en_i) || idx_rsv || arr_rsv);
    live  = hit && !bad;
    n_vec = live && cls_is_vec(cls);
    n_rd  = live ? fld.rd  : '0;
    n_rn  = live ? fld.rn  : '0;
    n_rm  = live ? rm_c    : '0;
    n_idx = live ? idx_c   : '0;
    n_es  = live ? es_c    : '0;
    n_ds  = live ? ds_c    : '0;
    n_cnt = live ? cnt_c   : '0;
    n_iw  = live ? iw_c    : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_o     <= 1'b0;
      undef_o     <= 1'b0;
      vector_o    <= 1'b0;
      rd_o        <= '0;
      rn_o        <= '0;
      rm_o        <= '0;
      index_o     <= '0;
      esize_o     <= '0;
      dsize_o     <= '0;
      count_o     <= '0;
      idx_width_o <= '0;
    end else begin
      match_o     <= hit;
      undef_o     <= bad;
      vector_o    <= n_vec;
      rd_o        <= n_rd;
      rn_o        <= n_rn;
      rm_o        <= n_rm;
      index_o     <= n_idx;
      esize_o     <= n_es;
      dsize_o     <= n_ds;
      count_o     <= n_cnt;
      idx_width_o <= n_iw;
    end
  end

endmodule

// File: rtl/mxe_decoder_chk.sv
module mxe_decoder_chk #(
  parameter int SIZE_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              half_en,
  input logic [1:0]        prec,
  input logic [2:0]        hlm,
  input logic [4:0]        rd_in,
  input logic              match_o,
  input logic              undef_o,
  input logic              vector_o,
  input logic [4:0]        rd_o,
  input logic [4:0]        rn_o,
  input logic [4:0]        rm_o,
  input logic [2:0]        index_o,
  input logic [SIZE_W-1:0] esize_o,
  input logic [SIZE_W-1:0] dsize_o,
  input logic [CNT_W-1:0]  count_o,
  input logic [SIZE_W-1:0] idx_width_o
);

  localparam int PW = SIZE_W + CNT_W;

  logic quiet;
  assign quiet = !vector_o && rd_o == 0 && rn_o == 0 && rm_o == 0 &&
                 index_o == 0 && esize_o == 0 && dsize_o == 0 &&
                 count_o == 0 && idx_width_o == 0;

  // R12
  undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
    undef_o |-> (match_o && quiet));

  // R1
  nomatch_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !match_o |-> (!undef_o && quiet));

  // R9
  size_product_chk: assert property (@(posedge clk) disable iff (rst)
    (match_o && !undef_o) |-> (PW'(count_o) * PW'(esize_o) == PW'(dsize_o)));

  // R9
  scalar_count_chk: assert property (@(posedge clk) disable iff (rst)
    (match_o && !undef_o && !vector_o) |-> (count_o == 1 && dsize_o == esize_o));

  // R4
  half_rm_range_chk: assert property (@(posedge clk) disable iff (rst)
    (match_o && !undef_o && esize_o == 16) |-> (rm_o < 5'd16));

  // R8
  idx_width_chk: assert property (@(posedge clk) disable iff (rst)
    (match_o && !undef_o) |-> (idx_width_o == 64 || idx_width_o == 128));

  // R11
  half_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (match_o && !$past(half_en) && $past(prec) == 2'b00) |-> undef_o);

  // R3
  dest_field_chk: assert property (@(posedge clk) disable iff (rst)
    (match_o && !undef_o) |-> (rd_o == $past(rd_in)));

  // R5
  half_index_chk: assert property (@(posedge clk) disable iff (rst)
    (match_o && !undef_o && $past(prec) == 2'b00) |-> (index_o == $past(hlm)));

endmodule

bind mxe_decoder mxe_decoder_chk #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .half_en     (half_en_i),
  .prec        (insn_i[23:22]),
  .hlm         ({insn_i[11], insn_i[21], insn_i[20]}),
  .rd_in       (insn_i[4:0]),
  .match_o     (match_o),
  .undef_o     (undef_o),
  .vector_o    (vector_o),
  .rd_o        (rd_o),
  .rn_o        (rn_o),
  .rm_o        (rm_o),
  .index_o     (index_o),
  .esize_o     (esize_o),
  .dsize_o     (dsize_o),
  .count_o     (count_o),
  .idx_width_o (idx_width_o)
);

// File: tb/mxe_decoder_test.sv
`timescale 1ns/1ps
module mxe_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn = 32'h0;
  logic        hen = 1'b0;

  logic       match_o, undef_o, vector_o;
  logic [4:0] rd_o, rn_o, rm_o;
  logic [2:0] index_o;
  logic [7:0] esize_o, dsize_o, idx_width_o;
  logic [3:0] count_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  mxe_decoder uut (
    .clk(clk), .rst(rst), .insn_i(insn), .half_en_i(hen),
    .match_o(match_o), .undef_o(undef_o), .vector_o(vector_o),
    .rd_o(rd_o), .rn_o(rn_o), .rm_o(rm_o), .index_o(index_o),
    .esize_o(esize_o), .dsize_o(dsize_o), .count_o(count_o),
    .idx_width_o(idx_width_o)
  );

  int e_match, e_undef, e_vec, e_rd, e_rn, e_rm, e_idx, e_es, e_ds, e_el, e_iw;

  task automatic expect_of(input logic [31:0] w, input logic f16);
    int fixed, scal, prec, half, sz, vec, und;
    e_match = 0; e_undef = 0; e_vec = 0; e_rd = 0; e_rn = 0; e_rm = 0;
    e_idx = 0; e_es = 0; e_ds = 0; e_el = 0; e_iw = 0;
    fixed = ((w & 32'hAF00_F400) == 32'h2F00_9000);
    scal  = w[28];
    prec  = w[23:22];
    if (!fixed || (scal && !w[30]) || prec == 1) return;
    half = (prec == 0);
    sz   = w[22];
    vec  = !scal;
    und  = (half && !f16) || (!half && sz && w[21]) || (!half && vec && sz && !w[30]);
    e_match = 1;
    if (und) begin e_undef = 1; return; end
    e_vec = vec;
    e_rd  = w[4:0];
    e_rn  = w[9:5];
    e_rm  = half ? w[19:16] : w[20:16];
    if (half)    e_idx = w[11] * 4 + w[21] * 2 + w[20];
    else if (!sz) e_idx = w[11] * 2 + w[21];
    else          e_idx = w[11];
    e_es = half ? 16 : (sz ? 64 : 32);
    e_iw = w[11] ? 128 : 64;
    if (vec) begin e_ds = w[30] ? 128 : 64; e_el = e_ds / e_es; end
    else     begin e_ds = e_es; e_el = 1; end
  endtask

  task automatic chk(input string tag, input int act, input int exp, input logic [31:0] w);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s word=%08h actual=%0d expected=%0d", tag, w, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic f16);
    string ut;
    insn = w; hen = f16;
    @(negedge clk);
    expect_of(w, f16);
    ut = e_undef ? "R12 " : "";
    chk({ut, "R1 R2 match"}, match_o, e_match, w);
    chk({ut, "R6,R10,R11 undef"}, undef_o, e_undef, w);
    chk({ut, "R13 vector"}, vector_o, e_vec, w);
    chk({ut, "R3 rd"}, rd_o, e_rd, w);
    chk({ut, "R3 rn"}, rn_o, e_rn, w);
    chk({ut, "R4 rm"}, rm_o, e_rm, w);
    chk({ut, "R5,R6 index"}, index_o, e_idx, w);
    chk({ut, "R7 esize"}, esize_o, e_es, w);
    chk({ut, "R8 idx_width"}, idx_width_o, e_iw, w);
    chk({ut, "R9 dsize"}, dsize_o, e_ds, w);
    chk({ut, "R9 count"}, count_o, e_el, w);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] lfsr;
    logic [31:0] good;
    int n;
    // R2: reset clears all outputs even with a valid word applied
    insn = 32'h6F80_9AB5; hen = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 reset match", match_o, 0, insn);
    chk("R2 reset esize", esize_o, 0, insn);
    chk("R2 reset rd", rd_o, 0, insn);
    chk("R2 reset idx_width", idx_width_o, 0, insn);
    rst = 1'b0;

    n = 0;
    for (int sc = 0; sc < 2; sc++)
      for (int q = 0; q < 2; q++)
        for (int p = 0; p < 4; p++)
          for (int hlm = 0; hlm < 8; hlm++)
            for (int rm = 0; rm < 16; rm++)
              for (int f = 0; f < 2; f++) begin
                logic [31:0] w;
                w = sc ? 32'h1F00_9000 : 32'h2F00_9000;
                w[29] = 1'b1;
                w[30] = q[0];
                w[23:22] = p[1:0];
                w[11] = hlm[2]; w[21] = hlm[1]; w[20] = hlm[0];
                w[19:16] = rm[3:0];
                w[4:0] = 5'(n * 7 + 3);
                w[9:5] = 5'(n * 11 + 1);
                n++;
                apply(w, f[0]);
              end

    // R1: corrupt each fixed bit of a valid vector word
    good = 32'h6F80_9AB5;
    for (int b = 0; b < 32; b++) apply(good ^ (32'h1 << b), 1'b1);

    // R1: pseudo-random words
    lfsr = 32'hACE1_2357;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr, lfsr[7]);
    end

    // R2: reset mid-stream clears a live result
    insn = good; hen = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R2 reset after use", match_o, 0, insn);
    chk("R2 reset after use dsize", dsize_o, 0, insn);
    summary();
  end

endmodule